// File: doc/BRIEF.md
# Dual-Edge Charger Status Interrupt Controller

This block watches the status conditions of a battery charger and folds them into one active-high interrupt request. Three level conditions are tracked: input supply valid, battery temperature valid (or battery present), and charge state machine sitting in its end-of-charge state. Each one can report an event when it enters its valid condition, when it leaves it, or both. Two timeout pulses, one for pre-charge and one for total charge time, each report an event of their own.

Every event is latched in a sticky event register, whatever the mask says. Software clears an event by writing 1 to its bit. An 8-bit read/write mask picks which latched events drive the interrupt line. The block also turns the charge state machine's 3-bit state into a 2-bit charger status code. Software reaches the mask, the event register and the status code through a simple register port: the address and write strobe are sampled on the clock edge, and read data is combinational from the address.

Top module: `chg_irq_ctrl`

## Requirements
- R1: While reset is held, the mask register (address 0) and the event register (address 1) read 0 and `irq` is low.
- R2: Address 0 is the mask register. A write stores all 8 bits, the register reads back what was written, and it changes only on a write to address 0.
- R3: The event bits for the level conditions are 6 (temperature rise), 5 (input rise), 4 (end-of-charge entered), 2 (temperature fall), 1 (input fall) and 0 (end-of-charge left). A rise or fall of a condition at the inputs before a clock edge sets its bit, and the bit reads 1 after that edge. End-of-charge is `chg_state` == 5.
- R4: A high `pre_tmo` before a clock edge sets event bit 7, and a high `tot_tmo` sets event bit 3.
- R5: `irq` is 1 exactly when some event bit and the mask bit at the same position are both 1. An event that is latched but masked leaves `irq` low. `irq` falls in the cycle after the last masked-in event is cleared.
- R6: Address 1 is the event register. Event bits are sticky. Writing 1 to a bit clears it, and writing 0 to a bit leaves it unchanged.
- R7: When a new event and a clear of the same bit arrive at the same edge, the bit stays 1.
- R8: `chg_code` and bits [5:4] of address 2 encode `chg_state` as follows. State 1 (sleep) gives 01. State 2 (pre-condition) gives 11. States 3 and 4 (fast-charge, top-off) give 10. States 0, 5, 6 and 7 (off, end-of-charge, suspend, fault) give 00.
- R9: Address 2 is read-only. Its other bits read 0, and writes to it change nothing. Address 3 reads 0.
- R10: No level-condition edge is reported at the first clock edge after reset is released. A condition that is already valid when reset ends leaves its event bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vin_ok | input | 1 | Input supply inside its valid window |
| temp_ok | input | 1 | Battery temperature valid or battery present |
| pre_tmo | input | 1 | Pre-charge timeout pulse |
| tot_tmo | input | 1 | Total-charge timeout pulse |
| chg_state | input | 3 | Charge state machine state |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request, active high |
| chg_code | output | 2 | Encoded charger status |

## Verification
The hardest case to reach is a new edge that lands on the same clock edge as a write-1-to-clear of that same bit. Random traffic almost never lines these up, so directed steps drive a timeout pulse and the matching clear in one cycle. The other hard case is a condition that is already valid when reset ends. To reach it, the bench holds the inputs valid through reset and reads the event register just after release. Random phases then mix condition toggles, timeout pulses, mask writes and clears, all against a bench model.

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl #(
  parameter int SW = 3,
  parameter logic [SW-1:0] ST_SLEEP = 3'd1,
  parameter logic [SW-1:0] ST_PRE   = 3'd2,
  parameter logic [SW-1:0] ST_FAST  = 3'd3,
  parameter logic [SW-1:0] ST_TOP   = 3'd4,
  parameter logic [SW-1:0] ST_EOC   = 3'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vin_ok,
  input  logic          temp_ok,
  input  logic          pre_tmo,
  input  logic          tot_tmo,
  input  logic [SW-1:0] chg_state,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic [1:0]    chg_code
);
  localparam logic [1:0] A_MASK = 2'd0, A_EVT = 2'd1, A_STAT = 2'd2;

  logic [7:0] mask_q, evt_q, evt_set, evt_clr;
  logic [2:0] prev_q, cur;
  logic       primed_q;

  assign cur = {temp_ok, vin_ok, chg_state == ST_EOC};

  wire [2:0] rise = primed_q ? ( cur & ~prev_q) : 3'b000;
  wire [2:0] fall = primed_q ? (~cur &  prev_q) : 3'b000;

  assign evt_set = {pre_tmo, rise, tot_tmo, fall};
  assign evt_clr = (reg_wr && reg_addr == A_EVT) ? reg_wdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      evt_q    <= '0;
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata;
      evt_q    <= (evt_q & ~evt_clr) | evt_set;
      prev_q   <= cur;
      primed_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (chg_state)
      ST_SLEEP:       chg_code = 2'b01;
      ST_PRE:         chg_code = 2'b11;
      ST_FAST, ST_TOP: chg_code = 2'b10;
      default:        chg_code = 2'b00;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = mask_q;
      A_EVT:   reg_rdata = evt_q;
      A_STAT:  reg_rdata = {2'b00, chg_code, 4'b0000};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/chg_irq_ctrl_chk.sv
module chg_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vin_ok,
  input logic [2:0] chg_state,
  input logic [1:0] chg_code,
  input logic       irq,
  input logic       reg_wr,
  input logic [7:0] mask_q,
  input logic [7:0] evt_q,
  input logic       primed_q
);
  a_r3_vin_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $rose(vin_ok)) |=> evt_q[5]);

  a_r3_vin_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $fell(vin_ok)) |=> evt_q[1]);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(mask_q));

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'h00) |-> !irq);

  a_r8_precond: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_state == 3'd2) |-> (chg_code == 2'b11));
endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .chg_state(chg_state),
  .chg_code(chg_code), .irq(irq), .reg_wr(reg_wr), .mask_q(mask_q),
  .evt_q(evt_q), .primed_q(primed_q)
);

// File: tb/chg_irq_ctrl_tb.sv
module chg_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vin_ok = 1'b0, temp_ok = 1'b0, pre_tmo = 1'b0, tot_tmo = 1'b0;
  logic [2:0] chg_state = 3'd0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;
  logic [1:0] chg_code;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_mask = 0, m_evt = 0;
  logic [2:0] m_prev = 0;
  bit m_primed = 0;

  chg_irq_ctrl u_dut (.*);

  always #4 clk = ~clk;

  function automatic logic [1:0] code_of(input logic [2:0] s);
    case (s)
      3'd1: return 2'b01;
      3'd2: return 2'b11;
      3'd3, 3'd4: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [7:0] rd_exp(input logic [1:0] a, input logic [2:0] s);
    case (a)
      2'd0: return m_mask;
      2'd1: return m_evt;
      2'd2: return {2'b00, code_of(s), 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic t, input logic p, input logic o,
                     input logic [2:0] s, input logic w, input logic [1:0] a,
                     input logic [7:0] d);
    logic [2:0] cur, rs, fl;
    logic [7:0] clr;
    @(negedge clk);
    vin_ok = v; temp_ok = t; pre_tmo = p; tot_tmo = o; chg_state = s;
    reg_wr = w; reg_addr = a; reg_wdata = d;
    #1;
    if (!w) chk(a == 2'd0 ? "R2 mask read" : a == 2'd1 ? "R6 event read" : "R9 status read",
                reg_rdata, rd_exp(a, s));
    chk("R5 irq", {7'b0, irq}, {7'b0, |(m_evt & m_mask)});
    chk("R8 chg_code", {6'b0, chg_code}, {6'b0, code_of(s)});
    @(posedge clk);
    cur = {t, v, s == 3'd5};
    rs = m_primed ? (cur & ~m_prev) : 3'b0;
    fl = m_primed ? (~cur & m_prev) : 3'b0;
    clr = (w && a == 2'd1) ? d : 8'h00;
    if (w && a == 2'd0) m_mask = d;
    m_evt = (m_evt & ~clr) | {p, rs, o, fl};
    m_prev = cur;
    m_primed = 1;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [7:0] exp);
    @(negedge clk);
    reg_wr = 0; reg_addr = a; pre_tmo = 0; tot_tmo = 0;
    #1;
    chk(tag, reg_rdata, exp);
    @(posedge clk);
    m_evt = m_evt;
    m_prev = {temp_ok, vin_ok, chg_state == 3'd5};
    m_primed = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    vin_ok = 1; temp_ok = 1; chg_state = 3'd5;
    repeat (2) @(posedge clk);
    @(negedge clk);
    reg_addr = 2'd0; #1; chk("R1 mask in reset", reg_rdata, 8'h00);
    reg_addr = 2'd1; #1; chk("R1 events in reset", reg_rdata, 8'h00);
    chk("R1 irq in reset", {7'b0, irq}, 8'h00);
    rst_n = 1;
    cyc(1, 1, 0, 0, 3'd5, 0, 2'd1, 8'h00);
    cyc(1, 1, 0, 0, 3'd5, 0, 2'd1, 8'h00);
    rd(2'd1, "R10 no edge at reset release", 8'h00);

    cyc(0, 1, 0, 0, 3'd5, 0, 2'd1, 8'h00);
    rd(2'd1, "R3 input fall bit 1", 8'h02);
    cyc(1, 0, 0, 0, 3'd3, 0, 2'd1, 8'h00);
    rd(2'd1, "R3 rise in, fall temp, leave eoc", 8'h27);
    cyc(1, 1, 0, 0, 3'd5, 1, 2'd1, 8'h00);
    rd(2'd1, "R6 write 0 keeps, R3 temp rise and eoc entry", 8'h77);
    cyc(1, 1, 0, 0, 3'd5, 1, 2'd0, 8'h01);
    rd(2'd0, "R2 mask readback", 8'h01);
    chk("R5 irq from masked-in bit 0", {7'b0, irq}, 8'h01);
    cyc(1, 1, 0, 0, 3'd5, 1, 2'd1, 8'h01);
    rd(2'd1, "R6 clear bit 0", 8'h76);
    chk("R5 irq falls after clear", {7'b0, irq}, 8'h00);
    cyc(1, 1, 0, 0, 3'd5, 1, 2'd1, 8'hFF);
    cyc(1, 1, 1, 0, 3'd5, 1, 2'd1, 8'h80);
    rd(2'd1, "R7 set wins over clear, R4 pre timeout", 8'h80);
    cyc(1, 1, 0, 1, 3'd5, 0, 2'd1, 8'h00);
    rd(2'd1, "R4 total timeout bit 3", 8'h88);
    cyc(1, 1, 0, 0, 3'd5, 1, 2'd2, 8'hFF);
    rd(2'd2, "R9 status write ignored", 8'h00);
    rd(2'd3, "R9 address 3 reads 0", 8'h00);
    rd(2'd0, "R9 mask untouched by status write", 8'h01);
    for (int s = 0; s < 8; s++) begin
      cyc(1, 1, 0, 0, s[2:0], 0, 2'd2, 8'h00);
    end

    for (int i = 0; i < 3000; i++) begin
      logic w;
      logic [1:0] a;
      w = ($urandom % 4) == 0;
      a = $urandom % 4;
      cyc(($urandom % 8) != 0 ? vin_ok : ~vin_ok,
          ($urandom % 8) != 0 ? temp_ok : ~temp_ok,
          ($urandom % 16) == 0, ($urandom % 16) == 0,
          ($urandom % 4) != 0 ? chg_state : 3'($urandom % 8),
          w, a, 8'($urandom));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule